// File: doc/BRIEF.md
# Floppy Controller Host Register Decode

This block sits between an 8-bit I/O bus and the rest of a floppy disk controller. It decodes an 8-port window with a chip select, read and write strobes and a 3-bit offset. It holds the control register that drives the drive selects, the motor enables, the controller soft reset and the gate on the DMA request and interrupt lines. It also returns a read-only change flag for the inserted medium.

The status and data ports are not stored here. A read of either returns the byte that an external command engine presents. A write to the data port becomes a one-cycle command-byte pulse to that engine. A read of the data port becomes a one-cycle pop pulse. The bus is split into a data input, a data output and a per-bit output enable, so that a pad ring can build the bidirectional pins. The change-flag port enables only its top bit, because a neighbouring device drives the other bits of the same port.

An access starts on the first clock edge where chip select and a strobe are both high. A strobe held high over many cycles counts as one access. The host must drop the strobe before it starts the next access.

Top module: `floppy_host_regs`

## Requirements
- R1: After the asynchronous reset (rstN low), the control register is all zero. So driveSel = 0, motorOn = 0, ctrlReset = 1, dmaReq = 0, irqReq = 0, cmdStrobe = 0 and fifoPop = 0.
- R2: A write access to offset 2 loads dataIn into the control register at the edge where the access starts. Its outputs reflect the new value right after that edge. Holding the strobe longer changes nothing further.
- R3: driveSel is one-hot or zero. Bit n is high only while control bit 2 is 1 and control bits [1:0] equal n.
- R4: ctrlReset is high exactly while control bit 2 is 0.
- R5: dmaReq equals engDrq and irqReq equals engIrq while control bit 3 is 1. Both are 0 while bit 3 is 0.
- R6: motorOn[n] follows control bit 4+n, for n = 0..3, whatever the state of bit 2.
- R7: A chip-selected read at offset 7 gives dataOe = 8'h80 and dataOut = {diskChanged, 7'b0}. diskChanged is 1 for a changed disk and 0 for one that is present and unchanged.
- R8: A chip-selected read at offset 4 returns mainStatus, and one at offset 5 returns fifoRdData. In both cases dataOe = 8'hFF.
- R9: A write access to offset 5 raises cmdStrobe for exactly one cycle after its first edge, with cmdByte holding the written byte. This holds however long the strobe stays high.
- R10: A read access to offset 5 raises fifoPop for exactly one cycle after its first edge.
- R11: dataOe and dataOut are 0 unless there is a chip-selected read at offset 4, 5 or 7. Offset 2 is write-only.
- R12: Writes to offsets other than 2 and 5, and any strobe while chipSel is low, leave the control register unchanged and produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chipSel | input | 1 | Port window select |
| rdStrobe | input | 1 | Read strobe |
| wrStrobe | input | 1 | Write strobe |
| addr | input | 3 | Port offset in window |
| dataIn | input | 8 | Write data from bus |
| dataOut | output | 8 | Read data to bus |
| dataOe | output | 8 | Per-bit output enable for bus pads |
| mainStatus | input | 8 | Status byte from command engine |
| fifoRdData | input | 8 | Data byte from command engine |
| diskChanged | input | 1 | Media change line |
| engDrq | input | 1 | Engine DMA request |
| engIrq | input | 1 | Engine interrupt request |
| dmaReq | output | 1 | Gated DMA request |
| irqReq | output | 1 | Gated interrupt request |
| driveSel | output | 4 | One-hot drive select |
| motorOn | output | 4 | Motor enables |
| ctrlReset | output | 1 | Soft reset to engine |
| cmdStrobe | output | 1 | Command byte pulse |
| cmdByte | output | 8 | Last command byte |
| fifoPop | output | 1 | Data read pulse |

## Verification
The bench holds write and read strobes over several cycles. A design that fires on level instead of on the first edge would emit repeated command or pop pulses, or reload the register. It walks every select value with the enable bit both set and cleared. A select decode that ignored the soft-reset bit would light a drive while the controller is held in reset. It reads the change port with the flag at both values and checks that only the top enable bit is driven, which catches a design that drives bits owned by the neighbouring device. It also writes to undecoded offsets and strobes with chip select low, to expose decode that is too wide.

// File: rtl/floppy_host_pkg.sv
package floppy_host_pkg;

  localparam int BUS_W     = 8;
  localparam int OFS_W     = 3;
  localparam int DRIVE_CNT = 4;

  // Port offsets inside the window
  localparam logic [OFS_W-1:0] OFS_CTRL   = 3'd2;
  localparam logic [OFS_W-1:0] OFS_STATUS = 3'd4;
  localparam logic [OFS_W-1:0] OFS_FIFO   = 3'd5;
  localparam logic [OFS_W-1:0] OFS_CHANGE = 3'd7;

  // Control register field positions
  localparam int CTL_SEL_LSB = 0;
  localparam int CTL_RUN_BIT = 2;
  localparam int CTL_GATE_BIT = 3;
  localparam int CTL_MOT_LSB = 4;

  // Change-port driven bit
  localparam int CHG_BIT = 7;

  typedef struct packed {
    logic ctrlLoad;   // edge pulse: load control register
    logic cmdPush;    // edge pulse: command byte written
    logic fifoTake;   // edge pulse: data byte read
    logic selStatus;  // level: read of status port
    logic selFifo;    // level: read of data port
    logic selChange;  // level: read of change port
  } hostStrobes_t;

endpackage

// File: rtl/fhr_ctrl.sv
module fhr_ctrl
  import floppy_host_pkg::*;
#(
  parameter int ADDR_W = OFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSel,
  input  logic              rdStrobe,
  input  logic              wrStrobe,
  input  logic [ADDR_W-1:0] addr,
  output hostStrobes_t      strb
);

  logic wrActive, rdActive;
  logic wrPrev, rdPrev;
  logic wrStart, rdStart;

  assign wrActive = chipSel && wrStrobe;
  assign rdActive = chipSel && rdStrobe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrev <= 1'b0;
      rdPrev <= 1'b0;
    end else begin
      wrPrev <= wrActive;
      rdPrev <= rdActive;
    end
  end

  assign wrStart = wrActive && !wrPrev;
  assign rdStart = rdActive && !rdPrev;

  always_comb begin
    strb = '0;
    strb.ctrlLoad  = wrStart && (addr == ADDR_W'(OFS_CTRL));
    strb.cmdPush   = wrStart && (addr == ADDR_W'(OFS_FIFO));
    strb.fifoTake  = rdStart && (addr == ADDR_W'(OFS_FIFO));
    strb.selStatus = rdActive && (addr == ADDR_W'(OFS_STATUS));
    strb.selFifo   = rdActive && (addr == ADDR_W'(OFS_FIFO));
    strb.selChange = rdActive && (addr == ADDR_W'(OFS_CHANGE));
  end

endmodule

// File: rtl/fhr_datapath.sv
module fhr_datapath
  import floppy_host_pkg::*;
#(
  parameter int DATA_W     = BUS_W,
  parameter int NUM_DRIVES = DRIVE_CNT
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  hostStrobes_t          strb,
  input  logic [DATA_W-1:0]     dataIn,
  input  logic [DATA_W-1:0]     mainStatus,
  input  logic [DATA_W-1:0]     fifoRdData,
  input  logic                  diskChanged,
  input  logic                  engDrq,
  input  logic                  engIrq,
  output logic [DATA_W-1:0]     dataOut,
  output logic [DATA_W-1:0]     dataOe,
  output logic                  dmaReq,
  output logic                  irqReq,
  output logic [NUM_DRIVES-1:0] driveSel,
  output logic [NUM_DRIVES-1:0] motorOn,
  output logic                  ctrlReset,
  output logic                  cmdStrobe,
  output logic [DATA_W-1:0]     cmdByte,
  output logic                  fifoPop
);

  localparam int SEL_W = $clog2(NUM_DRIVES);

  logic [DATA_W-1:0] ctrlReg;
  logic              runBit;
  logic [SEL_W-1:0]  selField;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      cmdStrobe <= 1'b0;
      cmdByte   <= '0;
      fifoPop   <= 1'b0;
    end else begin
      if (strb.ctrlLoad) ctrlReg <= dataIn;
      if (strb.cmdPush) cmdByte <= dataIn;
      cmdStrobe <= strb.cmdPush;
      fifoPop   <= strb.fifoTake;
    end
  end

  assign runBit    = ctrlReg[CTL_RUN_BIT];
  assign selField  = ctrlReg[CTL_SEL_LSB +: SEL_W];
  assign ctrlReset = !runBit;
  assign dmaReq    = engDrq && ctrlReg[CTL_GATE_BIT];
  assign irqReq    = engIrq && ctrlReg[CTL_GATE_BIT];
  assign motorOn   = ctrlReg[CTL_MOT_LSB +: NUM_DRIVES];

  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_sel
    assign driveSel[d] = runBit && (selField == SEL_W'(d));
  end

  always_comb begin
    dataOut = '0;
    dataOe  = '0;
    if (strb.selStatus) begin
      dataOut = mainStatus;
      dataOe  = '1;
    end else if (strb.selFifo) begin
      dataOut = fifoRdData;
      dataOe  = '1;
    end else if (strb.selChange) begin
      dataOut[CHG_BIT] = diskChanged;
      dataOe[CHG_BIT]  = 1'b1;
    end
  end

endmodule

// File: rtl/floppy_host_regs.sv
module floppy_host_regs
  import floppy_host_pkg::*;
#(
  parameter int DATA_W     = BUS_W,
  parameter int ADDR_W     = OFS_W,
  parameter int NUM_DRIVES = DRIVE_CNT
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  chipSel,
  input  logic                  rdStrobe,
  input  logic                  wrStrobe,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     dataIn,
  output logic [DATA_W-1:0]     dataOut,
  output logic [DATA_W-1:0]     dataOe,
  input  logic [DATA_W-1:0]     mainStatus,
  input  logic [DATA_W-1:0]     fifoRdData,
  input  logic                  diskChanged,
  input  logic                  engDrq,
  input  logic                  engIrq,
  output logic                  dmaReq,
  output logic                  irqReq,
  output logic [NUM_DRIVES-1:0] driveSel,
  output logic [NUM_DRIVES-1:0] motorOn,
  output logic                  ctrlReset,
  output logic                  cmdStrobe,
  output logic [DATA_W-1:0]     cmdByte,
  output logic                  fifoPop
);

  hostStrobes_t strb;

  fhr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .rdStrobe(rdStrobe),
    .wrStrobe(wrStrobe), .addr(addr), .strb(strb)
  );

  fhr_datapath #(.DATA_W(DATA_W), .NUM_DRIVES(NUM_DRIVES)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .dataIn(dataIn),
    .mainStatus(mainStatus), .fifoRdData(fifoRdData),
    .diskChanged(diskChanged), .engDrq(engDrq), .engIrq(engIrq),
    .dataOut(dataOut), .dataOe(dataOe), .dmaReq(dmaReq), .irqReq(irqReq),
    .driveSel(driveSel), .motorOn(motorOn), .ctrlReset(ctrlReset),
    .cmdStrobe(cmdStrobe), .cmdByte(cmdByte), .fifoPop(fifoPop)
  );

endmodule

// File: rtl/fhr_checker.sv
module fhr_checker #(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 3,
  parameter int NUM_DRIVES = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  chipSel,
  input logic                  rdStrobe,
  input logic                  wrStrobe,
  input logic [ADDR_W-1:0]     addr,
  input logic [DATA_W-1:0]     dataOe,
  input logic [NUM_DRIVES-1:0] driveSel,
  input logic                  ctrlReset,
  input logic                  cmdStrobe,
  input logic                  fifoPop,
  input logic                  dmaReq,
  input logic                  engDrq
);

  // R3
  drvsel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(driveSel));

  // R3
  drvsel_in_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlReset |-> (driveSel == '0));

  // R5
  dma_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> engDrq);

  // R7
  change_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chipSel && rdStrobe && addr == ADDR_W'(7)) |-> (dataOe == DATA_W'(8'h80)));

  // R11
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(chipSel && rdStrobe) |-> (dataOe == '0));

  // R9
  cmd_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |=> !cmdStrobe);

  // R9
  cmd_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |-> $past(chipSel && wrStrobe && addr == ADDR_W'(5)));

  // R10
  pop_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> $past(chipSel && rdStrobe && addr == ADDR_W'(5)));

  // R10
  pop_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |=> !fifoPop);

endmodule

bind floppy_host_regs fhr_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_DRIVES(NUM_DRIVES)
) u_chk (
  .clk(clk), .rstN(rstN), .chipSel(chipSel), .rdStrobe(rdStrobe),
  .wrStrobe(wrStrobe), .addr(addr), .dataOe(dataOe), .driveSel(driveSel),
  .ctrlReset(ctrlReset), .cmdStrobe(cmdStrobe), .fifoPop(fifoPop),
  .dmaReq(dmaReq), .engDrq(engDrq)
);

// File: tb/tb_floppy_host_regs.sv
`timescale 1ns/1ps
module tb_floppy_host_regs;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       chipSel = 1'b0, rdStrobe = 1'b0, wrStrobe = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] dataIn = '0, mainStatus = '0, fifoRdData = '0;
  logic       diskChanged = 1'b0, engDrq = 1'b0, engIrq = 1'b0;
  logic [7:0] dataOut, dataOe, cmdByte;
  logic       dmaReq, irqReq, ctrlReset, cmdStrobe, fifoPop;
  logic [3:0] driveSel, motorOn;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  floppy_host_regs dut (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .rdStrobe(rdStrobe),
    .wrStrobe(wrStrobe), .addr(addr), .dataIn(dataIn), .dataOut(dataOut),
    .dataOe(dataOe), .mainStatus(mainStatus), .fifoRdData(fifoRdData),
    .diskChanged(diskChanged), .engDrq(engDrq), .engIrq(engIrq),
    .dmaReq(dmaReq), .irqReq(irqReq), .driveSel(driveSel), .motorOn(motorOn),
    .ctrlReset(ctrlReset), .cmdStrobe(cmdStrobe), .cmdByte(cmdByte),
    .fifoPop(fifoPop)
  );

  // Behavioural reference: control byte, access history, pulses
  int  mCtrl = 0;
  bit  mWrHeld = 0, mRdHeld = 0;
  bit  mCmd = 0, mPop = 0;
  int  mCmdByte = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCtrl <= 0; mWrHeld <= 0; mRdHeld <= 0;
      mCmd <= 0; mPop <= 0; mCmdByte <= 0;
    end else begin
      bit wNew, rNew;
      wNew = chipSel && wrStrobe && !mWrHeld;
      rNew = chipSel && rdStrobe && !mRdHeld;
      if (wNew && addr == 2) mCtrl <= int'(dataIn);
      if (wNew && addr == 5) mCmdByte <= int'(dataIn);
      mCmd <= wNew && addr == 5;
      mPop <= rNew && addr == 5;
      mWrHeld <= chipSel && wrStrobe;
      mRdHeld <= chipSel && rdStrobe;
    end
  end

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Compare every output on every falling edge
  always @(negedge clk) begin
    if (!finished) begin
      int eSel, eOe, eOut;
      bit rdOn;
      eSel = ((mCtrl >> 2) & 1) ? (1 << (mCtrl & 3)) : 0;
      rdOn = chipSel && rdStrobe;
      eOe = 0; eOut = 0;
      if (rdOn && addr == 4) begin eOe = 'hFF; eOut = int'(mainStatus); end
      else if (rdOn && addr == 5) begin eOe = 'hFF; eOut = int'(fifoRdData); end
      else if (rdOn && addr == 7) begin eOe = 'h80; eOut = diskChanged ? 'h80 : 0; end
      check("R3 driveSel", int'(driveSel), eSel);
      check("R6 motorOn", int'(motorOn), (mCtrl >> 4) & 'hF);
      check("R4 ctrlReset", int'(ctrlReset), ((mCtrl >> 2) & 1) ? 0 : 1);
      check("R5 dmaReq", int'(dmaReq), int'(engDrq) & ((mCtrl >> 3) & 1));
      check("R5 irqReq", int'(irqReq), int'(engIrq) & ((mCtrl >> 3) & 1));
      check("R9 cmdStrobe", int'(cmdStrobe), int'(mCmd));
      check("R9 cmdByte", int'(cmdByte), mCmdByte);
      check("R10 fifoPop", int'(fifoPop), int'(mPop));
      check("R11 dataOe", int'(dataOe), eOe);
      check("R11 dataOut", int'(dataOut), eOut);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(logic [2:0] a, logic [7:0] d, int hold, bit cs);
    @(negedge clk);
    chipSel = cs; wrStrobe = 1'b1; addr = a; dataIn = d;
    repeat (hold) @(negedge clk);
    chipSel = 1'b0; wrStrobe = 1'b0; dataIn = 8'h00;
  endtask

  task automatic busRead(logic [2:0] a, int hold);
    @(negedge clk);
    chipSel = 1'b1; rdStrobe = 1'b1; addr = a;
    repeat (hold) @(negedge clk);
    chipSel = 1'b0; rdStrobe = 1'b0;
  endtask

  initial begin
    idle(3);
    // R1: reset state
    check("R1 reset driveSel", int'(driveSel), 0);
    check("R1 reset ctrlReset", int'(ctrlReset), 1);
    rstN = 1'b1;
    idle(2);
    check("R1 post-reset motorOn", int'(motorOn), 0);

    // R2/R3/R5/R6: run, gate, select drive 0, motor 0
    engDrq = 1'b1; engIrq = 1'b1;
    busWrite(3'd2, 8'h1C, 3, 1'b1);
    idle(1);
    check("R2 select first", int'(driveSel), 1);
    check("R5 gated req", int'(dmaReq), 1);
    // every select value, running and held in reset
    for (int s = 0; s < 4; s++) begin
      busWrite(3'd2, 8'(8'hF4 | s), 1, 1'b1);
      idle(1);
      check("R3 select walk", int'(driveSel), 1 << s);
      busWrite(3'd2, 8'(8'hA0 | s), 2, 1'b1);
      idle(1);
      check("R4 held reset no select", int'(driveSel), 0);
      check("R6 motors in reset", int'(motorOn), 'hA);
    end
    busWrite(3'd2, 8'h06, 1, 1'b1);
    idle(1);
    check("R5 gate closed", int'(irqReq), 0);

    // R12: undecoded writes and deselected writes
    for (int a = 0; a < 8; a++) begin
      if (a != 2 && a != 5) busWrite(3'(a), 8'hFF, 2, 1'b1);
    end
    busWrite(3'd2, 8'hFF, 2, 1'b0);
    busWrite(3'd5, 8'h33, 2, 1'b0);
    idle(2);
    check("R12 ctrl unchanged", int'(driveSel), 'h4);
    check("R12 no cmd", int'(cmdByte), 0);

    // R9: held command write, then a second one
    busWrite(3'd5, 8'hA5, 4, 1'b1);
    idle(1);
    check("R9 cmd byte", int'(cmdByte), 'hA5);
    busWrite(3'd5, 8'h3C, 1, 1'b1);
    idle(2);

    // R7: change port both values
    diskChanged = 1'b1;
    busRead(3'd7, 2);
    diskChanged = 1'b0;
    busRead(3'd7, 2);
    // R8/R10: status and data reads
    mainStatus = 8'h81; fifoRdData = 8'h5A;
    busRead(3'd4, 2);
    busRead(3'd5, 4);
    fifoRdData = 8'hC3;
    busRead(3'd5, 1);
    // R11: write-only control and unused offsets read
    busRead(3'd2, 2);
    busRead(3'd1, 1);
    busRead(3'd6, 1);
    idle(2);

    // R1: reset mid-run
    busWrite(3'd2, 8'h3D, 1, 1'b1);
    idle(1);
    rstN = 1'b0;
    idle(2);
    check("R1 async reset ctrl", int'(motorOn), 0);
    rstN = 1'b1;
    idle(3);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule